// File: doc/BRIEF.md
# Instruction Fetch Cache Controller with Local Program Counter

This controller sits between the instruction decoder and an array of instruction RAM slices, which together hold 512 words of 32 bits. It keeps its own copy of the fetch program counter. Every cycle it drives a 9-bit word address to the RAMs. Without a branch, the address advances by one. When the decoder raises the branch strobe, the target is taken and its low bits reach the RAMs in that same cycle. The tag compare for the same address runs alongside the RAM read, so a branch adds no address cycle ahead of the read.

The cache is direct mapped, with four-word lines. Each line has a valid bit and a tag. A miss stops the program counter. The controller then asks a lower memory for the line, writes the four returned words into the RAMs in word order, and marks the line valid. After that it looks up the missed address again.

At boot, the fetch address starts at 0x0020 and every line is invalid. An external force input turns every lookup into a miss, so that lines can be validated from memory. The one exception is the single lookup right after a fill, which is what lets execution move forward while the input is held.

Top module: `icc_top`

## Requirements
- R1: While reset is low, and right after it is released, the lookup address is 0x0020 and every line is invalid. The first lookup therefore misses, and in the following cycle fillReq rises with fillLineAddr = 0x0020.
- R2: After a hit in a cycle with no branch taken, the next lookup address is the previous one plus one, modulo 2^16. ramAddr carries its low 9 bits, so it wraps from 0x1FF to 0x000.
- R3: A branch is taken only in a lookup cycle (fillReq low) with branchValid high. In that cycle ramAddr equals branchTarget[8:0], the lookup uses branchTarget, and the next sequential lookup is branchTarget + 1 if the target hits.
- R4: fetchValid is high in a lookup cycle exactly when the line at index bits [8:2] of the lookup address is valid and its stored tag equals bits [15:9], subject to R8. fetchPc always shows the lookup address.
- R5: After a miss, fillReq is high from the next cycle until the fourth word is written. fillLineAddr is the missed address with bits [1:0] cleared and stays stable during the fill. fetchValid is low during the fill.
- R6: In a fill cycle, ramWe equals fillValid. ramAddr is {line index, word count}, where the word count runs 0, 1, 2, 3 over the accepted words. ramWdata equals fillData.
- R7: The cycle after the fourth word is written is a lookup of the missed address, and that lookup hits.
- R8: While initForce is high, every lookup misses except the one in the cycle directly after a fill completes.
- R9: branchValid has no effect during a fill, and fillValid outside a fill causes no RAM write.
- R10: A lookup whose index matches a valid line but whose tag differs misses. The fill then replaces that line's tag, so the old address misses afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| branchValid | input | 1 | Branch strobe from the decoder |
| branchTarget | input | 16 | Branch target word address |
| initForce | input | 1 | Forces lookups to miss (boot validation) |
| fillValid | input | 1 | Lower memory presents a fill word |
| fillData | input | 32 | Fill word from lower memory |
| ramAddr | output | 9 | Word address to the instruction RAM slices |
| ramWe | output | 1 | RAM write enable during fill |
| ramWdata | output | 32 | RAM write data |
| fillReq | output | 1 | Line fill request |
| fillLineAddr | output | 16 | Base word address of the line being filled |
| fetchValid | output | 1 | RAM word at this address is a hit for the decoder |
| fetchPc | output | 16 | Address looked up this cycle |

## Verification
The bench first runs straight-line code from the reset address. This separates correct sequencing and cold-miss fills from fills that arrive with gaps in fillValid. It then holds the branch strobe high across fill cycles and lookup cycles, which shows whether branches are ignored in the right place. Runs across 0x1FF→0x200 and 0xFFFF→0x0000 expose faults in wrap and tag extraction. An aliasing branch to 0x0220 and back to 0x0020 separates index matches from tag matches. Finally, a stretch with the force input held separates the forced miss from the single retry hit that lets boot move forward.

// File: rtl/icc_pkg.sv
package icc_pkg;
  typedef enum logic {ST_LOOKUP = 1'b0, ST_FILL = 1'b1} iccState_t;

  typedef struct packed {
    logic takeBranch;
    logic advance;
    logic captureMiss;
    logic fillDone;
    logic fillSel;
  } iccStrobes_t;
endpackage

// File: rtl/icc_ctrl.sv
module icc_ctrl
  import icc_pkg::*;
#(
  parameter int OFF_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             branchValid,
  input  logic             initForce,
  input  logic             fillValid,
  input  logic             tagHit,
  output iccStrobes_t      st,
  output logic [OFF_W-1:0] wordCnt,
  output logic             fetchValid,
  output logic             fillReq,
  output logic             ramWe
);
  localparam logic [OFF_W-1:0] LAST_WORD = {OFF_W{1'b1}};

  iccState_t        stateQ;
  logic [OFF_W-1:0] cntQ;
  logic             retryQ;
  logic             hitEff;

  always_comb begin
    st     = '0;
    hitEff = tagHit && (!initForce || retryQ);
    if (stateQ == ST_LOOKUP) begin
      st.takeBranch  = branchValid;
      st.advance     = hitEff;
      st.captureMiss = !hitEff;
    end else begin
      st.fillSel  = 1'b1;
      st.fillDone = fillValid && (cntQ == LAST_WORD);
    end
  end

  assign fetchValid = (stateQ == ST_LOOKUP) && hitEff;
  assign fillReq    = (stateQ == ST_FILL);
  assign ramWe      = (stateQ == ST_FILL) && fillValid;
  assign wordCnt    = cntQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_LOOKUP;
      cntQ   <= '0;
      retryQ <= 1'b0;
    end else if (stateQ == ST_LOOKUP) begin
      retryQ <= 1'b0;
      if (st.captureMiss) begin
        stateQ <= ST_FILL;
        cntQ   <= '0;
      end
    end else if (fillValid) begin
      cntQ <= cntQ + 1'b1;
      if (st.fillDone) begin
        stateQ <= ST_LOOKUP;
        retryQ <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/icc_datapath.sv
module icc_datapath
  import icc_pkg::*;
#(
  parameter int              ADDR_W   = 16,
  parameter int              IDX_W    = 9,
  parameter int              OFF_W    = 2,
  parameter logic [ADDR_W-1:0] RESET_PC = 16'h0020
) (
  input  logic              clk,
  input  logic              rstN,
  input  iccStrobes_t       st,
  input  logic [OFF_W-1:0]  wordCnt,
  input  logic [ADDR_W-1:0] branchTarget,
  output logic              tagHit,
  output logic [IDX_W-1:0]  ramAddr,
  output logic [ADDR_W-1:0] fillLineAddr,
  output logic [ADDR_W-1:0] fetchPc
);
  localparam int LINE_W = IDX_W - OFF_W;
  localparam int LINES  = 1 << LINE_W;
  localparam int TAG_W  = ADDR_W - IDX_W;

  logic [ADDR_W-1:0]       pcQ;
  logic [ADDR_W-1:OFF_W]   missLineQ;
  logic [LINES-1:0]        validQ;
  logic [TAG_W-1:0]        tagQ [LINES];

  logic [ADDR_W-1:0]       lookupAddr;
  logic [LINE_W-1:0]       lookIdx;
  logic [TAG_W-1:0]        lookTag;
  logic [LINE_W-1:0]       missIdx;
  logic [TAG_W-1:0]        missTag;

  assign lookupAddr   = st.takeBranch ? branchTarget : pcQ;
  assign lookIdx      = lookupAddr[IDX_W-1:OFF_W];
  assign lookTag      = lookupAddr[ADDR_W-1:IDX_W];
  assign missIdx      = missLineQ[IDX_W-1:OFF_W];
  assign missTag      = missLineQ[ADDR_W-1:IDX_W];

  assign tagHit       = validQ[lookIdx] && (tagQ[lookIdx] == lookTag);
  assign ramAddr      = st.fillSel ? {missIdx, wordCnt} : lookupAddr[IDX_W-1:0];
  assign fillLineAddr = {missLineQ, {OFF_W{1'b0}}};
  assign fetchPc      = lookupAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ       <= RESET_PC;
      missLineQ <= '0;
    end else if (st.advance) begin
      pcQ <= lookupAddr + 1'b1;
    end else if (st.captureMiss) begin
      pcQ       <= lookupAddr;
      missLineQ <= lookupAddr[ADDR_W-1:OFF_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
    end else if (st.fillDone) begin
      validQ[missIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (st.fillDone) begin
      tagQ[missIdx] <= missTag;
    end
  end
endmodule

// File: rtl/icc_top.sv
module icc_top
  import icc_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter int                IDX_W    = 9,
  parameter int                OFF_W    = 2,
  parameter int                DATA_W   = 32,
  parameter logic [ADDR_W-1:0] RESET_PC = 16'h0020
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              branchValid,
  input  logic [ADDR_W-1:0] branchTarget,
  input  logic              initForce,
  input  logic              fillValid,
  input  logic [DATA_W-1:0] fillData,
  output logic [IDX_W-1:0]  ramAddr,
  output logic              ramWe,
  output logic [DATA_W-1:0] ramWdata,
  output logic              fillReq,
  output logic [ADDR_W-1:0] fillLineAddr,
  output logic              fetchValid,
  output logic [ADDR_W-1:0] fetchPc
);
  iccStrobes_t      st;
  logic [OFF_W-1:0] wordCnt;
  logic             tagHit;

  icc_ctrl #(.OFF_W(OFF_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .branchValid(branchValid), .initForce(initForce),
    .fillValid(fillValid), .tagHit(tagHit), .st(st), .wordCnt(wordCnt),
    .fetchValid(fetchValid), .fillReq(fillReq), .ramWe(ramWe)
  );

  icc_datapath #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .RESET_PC(RESET_PC)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .wordCnt(wordCnt), .branchTarget(branchTarget),
    .tagHit(tagHit), .ramAddr(ramAddr), .fillLineAddr(fillLineAddr), .fetchPc(fetchPc)
  );

  assign ramWdata = fillData;
endmodule

// File: rtl/icc_checker.sv
module icc_checker #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 9
) (
  input logic              clk,
  input logic              rstN,
  input logic              branchValid,
  input logic [ADDR_W-1:0] branchTarget,
  input logic              initForce,
  input logic [IDX_W-1:0]  ramAddr,
  input logic              ramWe,
  input logic              fillReq,
  input logic [ADDR_W-1:0] fillLineAddr,
  input logic              fetchValid,
  input logic [ADDR_W-1:0] fetchPc
);
  p_fill_no_fetch_r5: assert property (@(posedge clk) disable iff (!rstN)
    fillReq |-> !fetchValid);

  p_miss_enters_fill_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!fillReq && !fetchValid) |=> fillReq);

  p_fill_line_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    (fillReq && $past(fillReq)) |-> $stable(fillLineAddr));

  p_write_only_in_fill_r9: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> fillReq);

  p_sequential_r2: assert property (@(posedge clk) disable iff (!rstN)
    (fetchValid ##1 (fetchValid && !branchValid)) |-> (fetchPc == ADDR_W'($past(fetchPc) + 1'b1)));

  p_branch_addr_r3: assert property (@(posedge clk) disable iff (!rstN)
    (branchValid && !fillReq) |-> (ramAddr == branchTarget[IDX_W-1:0]));

  p_force_miss_r8: assert property (@(posedge clk) disable iff (!rstN)
    (initForce && !$past(ramWe)) |-> !fetchValid);
endmodule

bind icc_top icc_checker #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .branchValid(branchValid), .branchTarget(branchTarget),
  .initForce(initForce), .ramAddr(ramAddr), .ramWe(ramWe), .fillReq(fillReq),
  .fillLineAddr(fillLineAddr), .fetchValid(fetchValid), .fetchPc(fetchPc)
);

// File: tb/tb_icc_top.sv
`timescale 1ns/1ps
module tb_icc_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        branchValid = 1'b0;
  logic [15:0] branchTarget = '0;
  logic        initForce = 1'b0;
  logic        fillValid = 1'b0;
  logic [31:0] fillData = '0;
  logic [8:0]  ramAddr;
  logic        ramWe;
  logic [31:0] ramWdata;
  logic        fillReq;
  logic [15:0] fillLineAddr;
  logic        fetchValid;
  logic [15:0] fetchPc;

  icc_top dut (
    .clk(clk), .rstN(rstN), .branchValid(branchValid), .branchTarget(branchTarget),
    .initForce(initForce), .fillValid(fillValid), .fillData(fillData),
    .ramAddr(ramAddr), .ramWe(ramWe), .ramWdata(ramWdata), .fillReq(fillReq),
    .fillLineAddr(fillLineAddr), .fetchValid(fetchValid), .fetchPc(fetchPc)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;
  string hitTag = "R4";

  // behavioural reference state
  int  mPc = 'h20;
  int  mMiss = 0;
  int  mCnt = 0;
  bit  mFill = 1'b0;
  bit  mRetry = 1'b0;
  bit  mValid [128];
  int  mTag [128];

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  task automatic step(input bit bv, input int tgt, input bit ini);
    int look, idx, tg, line;
    bit hit;
    branchValid  = bv;
    branchTarget = 16'(tgt);
    initForce    = ini;
    fillValid    = (cyc % 3) != 2;
    fillData     = {16'hC0DE, 16'(cyc)};
    #1;
    if (!mFill) begin
      look = bv ? (tgt & 'hFFFF) : mPc;
      idx  = (look >> 2) & 127;
      tg   = look >> 9;
      hit  = mValid[idx] && (mTag[idx] == tg) && (!ini || mRetry);
      chk(ini ? "R8" : (mRetry ? "R7" : hitTag), fetchValid, hit);
      chk("R4", fetchPc, look);
      chk(bv ? "R3" : "R2", ramAddr, look & 'h1FF);
      chk("R5", fillReq, 0);
      chk("R9", ramWe, 0);
      mRetry = 1'b0;
      if (hit) mPc = (look + 1) & 'hFFFF;
      else begin
        mMiss = look; mPc = look; mFill = 1'b1; mCnt = 0;
      end
    end else begin
      line = mMiss & 'hFFFC;
      chk("R5", fetchValid, 0);
      chk("R5", fillReq, 1);
      chk("R5", fillLineAddr, line);
      chk("R6", ramAddr, (line & 'h1FF) | mCnt);
      chk("R6", ramWe, fillValid);
      if (fillValid) begin
        chk("R6", ramWdata, fillData);
        if (mCnt == 3) begin
          mValid[(mMiss >> 2) & 127] = 1'b1;
          mTag[(mMiss >> 2) & 127]   = mMiss >> 9;
          mFill = 1'b0; mRetry = 1'b1;
        end else mCnt++;
      end
    end
    cyc++;
    @(negedge clk);
  endtask

  task automatic run(input int n, input bit ini);
    for (int i = 0; i < n; i++) step(1'b0, 0, ini);
  endtask

  task automatic jump(input int tgt, input bit ini);
    bit wasLookup;
    do begin
      wasLookup = !mFill;
      step(1'b1, tgt, ini);
    end while (!wasLookup);
  endtask

  initial begin
    #100000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) begin mValid[i] = 1'b0; mTag[i] = 0; end
    repeat (3) @(negedge clk);
    #1;
    chk("R1", ramAddr, 'h20);
    chk("R1", fetchValid, 0);
    chk("R1", fillReq, 0);
    @(negedge clk);
    rstN = 1'b1;
    // R1, R2, R5, R6, R7: cold start and straight-line fetch, with fillValid gaps
    run(40, 1'b0);
    // R3, R9: branch strobe held high across fill and lookup cycles
    for (int i = 0; i < 12; i++) step(1'b1, 'h22, 1'b0);
    // R2: RAM address wrap 0x1FF -> 0x000
    jump('h1FC, 1'b0);
    run(30, 1'b0);
    // R10: same index, different tag
    hitTag = "R10";
    jump('h220, 1'b0);
    run(12, 1'b0);
    jump('h20, 1'b0);
    run(8, 1'b0);
    hitTag = "R4";
    // R8: forced misses with retry progress
    run(20, 1'b1);
    jump('h21, 1'b1);
    run(10, 1'b1);
    run(5, 1'b0);
    // R2: 16-bit program counter wrap
    jump('hFFFE, 1'b0);
    run(20, 1'b0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule